// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block turns the one-bit output of an oversampling modulator into multi-bit conversion results. It builds a cascade of running-sum integrators, clocked by a modulator-rate enable, followed by a chain of differencing stages that runs once per output. The response is either third-order or fourth-order sinc. A filter word sets the decimation ratio in steps of sixteen modulator samples. A larger word gives slower but less noisy results.

Both configuration inputs are captured only on a restart pulse. A restart also empties every stage of the filter. The block counts the results that follow each restart. Its settled flag goes high with the first result whose whole impulse response lies after the restart. That is the third result for the third-order response and the fourth result for the fourth-order response. A host that switches the input channel pulses restart and then discards results until the flag is high.

The bitstream enters on a strobe with no ready: the modulator cannot be stalled, and every enabled cycle carries a sample. Results leave on a one-cycle valid strobe with no back-pressure. The result word holds its value until the next strobe, so a consumer can read it at any point before the next result arrives, which is at least sixteen enabled samples later.

Top module: `sinc_decim`

## Requirements
- R1: The decimation ratio is 16 × the captured filter word, and a captured word of 0 acts as 1. Exactly one result strobe follows each group of that many enabled samples counted from the restart.
- R2: `order_sel` = 0 selects the third-order response and 1 selects the fourth-order response. This input and `fs_word` are captured only in a restart cycle, and changing them at any other time has no effect on timing or values.
- R3: With a constant input, every settled result equals (16·FS)^K when the input is all ones, and equals 0 when the input is all zeros. K is the selected order (3 or 4).
- R4: With an input that alternates 1,0,1,0,… starting with 1 after the restart, every settled result equals (8·FS)·(16·FS)^(K−1).
- R5: `settled` is low after reset and after a restart. It rises in the same cycle as the K-th result strobe after the restart and then stays high until the next restart.
- R6: `result_valid` is a single-cycle pulse. It is high in the cycle that follows the clock edge after the edge that took the last sample of a group, and `result` changes only with it.
- R7: A restart clears all filter state, the sample count, the result word, the strobe and `settled`. A sample offered in the restart cycle is discarded.
- R8: In cycles where `mod_en` is low, `bit_in` has no effect on any later result.
- R9: Internal sums wrap modulo 2^W, with W = 4·⌈log2(16·(2^FS_W−1))⌉+1. Results after the settling point keep their exact value however long the conversion has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Modulator bit, taken when `mod_en` is high |
| mod_en | input | 1 | Modulator-rate sample strobe |
| order_sel | input | 1 | 0: third order, 1: fourth order (captured on restart) |
| fs_word | input | FS_W | Filter word, ratio = 16 × word (captured on restart) |
| restart | input | 1 | Clears the filter and captures the configuration |
| result | output | W | Latest conversion result, unsigned |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| settled | output | 1 | High once results cover only post-restart input |

## Verification
A result strobe is due in the cycle that follows the second clock edge counted from the edge that took the 16·FS-th sample of a group. The edge that takes the sample updates the integrators, and the next edge updates the differencing stages and the output register. The bench records, for every edge, whether a sample was taken and the running sample total. At each falling edge it derives the expected strobe from the values recorded two edges earlier, so a result that is early or late by one cycle is reported. `settled` is compared against the running result count in every cycle. Result values are checked against closed-form sums over a sweep of all filter words, both orders, three input patterns and gapped strobes.

// File: rtl/sinc_pkg.sv
`timescale 1ns/1ps
package sinc_pkg;
  localparam int MAX_ORDER = 4;
  localparam int RATIO_STEP = 16;

  typedef enum logic {
    ORD_SINC3 = 1'b0,
    ORD_SINC4 = 1'b1
  } order_e;

  function automatic int max_ratio(input int fs_w);
    return RATIO_STEP * ((1 << fs_w) - 1);
  endfunction

  function automatic int acc_w(input int fs_w);
    return MAX_ORDER * $clog2(max_ratio(fs_w)) + 1;
  endfunction
endpackage

// File: rtl/sinc_ctrl.sv
`timescale 1ns/1ps
module sinc_ctrl
  import sinc_pkg::*;
#(
  parameter int FS_W = 5,
  localparam int CNT_W = $clog2(max_ratio(FS_W))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_en,
  input  logic            restart,
  input  logic            order_sel,
  input  logic [FS_W-1:0] fs_word,
  output logic            step,
  output logic            clr,
  output logic            fire,
  output logic            ord4,
  output logic            res_valid,
  output logic            settled
);
  logic [FS_W-1:0]  fs_q;
  order_e           ord_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic             pend;
  logic [2:0]       outs;
  logic [2:0]       need;

  assign last_idx = CNT_W'({fs_q, 4'b0000}) - CNT_W'(1);
  assign need     = (ord_q == ORD_SINC4) ? 3'd4 : 3'd3;
  assign step     = mod_en & ~restart;
  assign clr      = restart;
  assign fire     = pend;
  assign ord4     = (ord_q == ORD_SINC4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= FS_W'(1);
      ord_q     <= ORD_SINC3;
      cnt       <= '0;
      pend      <= 1'b0;
      outs      <= '0;
      res_valid <= 1'b0;
      settled   <= 1'b0;
    end else if (restart) begin
      fs_q      <= (fs_word == '0) ? FS_W'(1) : fs_word;
      ord_q     <= order_e'(order_sel);
      cnt       <= '0;
      pend      <= 1'b0;
      outs      <= '0;
      res_valid <= 1'b0;
      settled   <= 1'b0;
    end else begin
      pend      <= 1'b0;
      res_valid <= pend;
      if (mod_en) begin
        if (cnt == last_idx) begin
          cnt  <= '0;
          pend <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      if (pend) begin
        if (outs < need) outs <= outs + 3'd1;
        if ((outs + 3'd1) >= need) settled <= 1'b1;
      end
    end
  end

  // R1: the sample counter never passes the end of its group
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

  // R2: configuration moves only on restart
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(fs_q) && $stable(ord_q)));

  // R6: the strobe never lasts two cycles
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: settling is announced together with a result
  p_settle_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> res_valid);

  // R7: a restart leaves no strobe and no settled state behind
  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!res_valid && !settled));
endmodule

// File: rtl/sinc_integ.sv
`timescale 1ns/1ps
module sinc_integ #(
  parameter int W      = 37,
  parameter int STAGES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic                      clr,
  input  logic                      bit_in,
  output logic [STAGES-1:0][W-1:0]  acc
);
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] addend;
    if (k == 0) begin : g_first
      assign addend = W'(bit_in);
    end else begin : g_rest
      assign addend = acc[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (step) q <= q + addend;
    end
    assign acc[k] = q;
  end

  // R8: without a sample strobe the running sums stay put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(acc));

  // R7: a clear empties every running sum
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
endmodule

// File: rtl/sinc_comb.sv
`timescale 1ns/1ps
module sinc_comb #(
  parameter int W      = 37,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         clr,
  input  logic         ord4,
  input  logic [W-1:0] tap_lo,
  input  logic [W-1:0] tap_hi,
  output logic [W-1:0] result
);
  logic [STAGES:0][W-1:0] w;

  assign w[0] = ord4 ? tap_hi : tap_lo;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [W-1:0] d;
    assign w[k+1] = w[k] - d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    d <= '0;
      else if (clr)  d <= '0;
      else if (fire) d <= w[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result <= '0;
    else if (clr)  result <= '0;
    else if (fire) result <= ord4 ? w[STAGES] : w[STAGES-1];
  end

  // R6: the result word changes only when a result is produced
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(result));
endmodule

// File: rtl/sinc_decim.sv
`timescale 1ns/1ps
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int FS_W = 5,
  localparam int RES_W = acc_w(FS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             mod_en,
  input  logic             order_sel,
  input  logic [FS_W-1:0]  fs_word,
  input  logic             restart,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             settled
);
  logic step, clr, fire, ord4;
  logic [MAX_ORDER-1:0][RES_W-1:0] acc;

  sinc_ctrl #(.FS_W(FS_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .restart   (restart),
    .order_sel (order_sel),
    .fs_word   (fs_word),
    .step      (step),
    .clr       (clr),
    .fire      (fire),
    .ord4      (ord4),
    .res_valid (result_valid),
    .settled   (settled)
  );

  sinc_integ #(.W(RES_W), .STAGES(MAX_ORDER)) integ_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .clr    (clr),
    .bit_in (bit_in),
    .acc    (acc)
  );

  sinc_comb #(.W(RES_W), .STAGES(MAX_ORDER)) comb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .clr    (clr),
    .ord4   (ord4),
    .tap_lo (acc[MAX_ORDER-2]),
    .tap_hi (acc[MAX_ORDER-1]),
    .result (result)
  );

  // R5: once settled, only a restart can drop the flag
  p_settled_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !restart) |=> settled);

  // R3: all-zero history right after a restart gives a zero first result
  p_zero_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (result == '0));
endmodule

// File: tb/sinc_decim_tb_top.sv
`timescale 1ns/1ps
module sinc_decim_tb_top;
  localparam int FS_W = 3;
  localparam int RW   = sinc_pkg::acc_w(FS_W);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bit_in = 1'b0;
  logic            mod_en = 1'b0;
  logic            order_sel = 1'b0;
  logic            restart = 1'b0;
  logic [FS_W-1:0] fs_word = '0;
  logic [RW-1:0]   result;
  logic            result_valid;
  logic            settled;

  int     errors = 0;
  int     checks = 0;
  bit     done = 1'b0;
  longint total = 0;
  longint t1 = 0;
  longint t2 = 0;
  bit     s1 = 1'b0;
  bit     s2 = 1'b0;
  int     outs = 0;
  longint ratio = 16;
  int     kord = 3;
  int     pat = 0;

  always #2 clk = ~clk;

  sinc_decim #(.FS_W(FS_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (bit_in),
    .mod_en       (mod_en),
    .order_sel    (order_sel),
    .fs_word      (fs_word),
    .restart      (restart),
    .result       (result),
    .result_valid (result_valid),
    .settled      (settled)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ipow(input longint b, input int e);
    longint r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic longint expect_val(input int p, input longint r, input int k);
    if (p == 0) return ipow(r, k);
    if (p == 1) return 0;
    return (r / 2) * ipow(r, k - 1);
  endfunction

  task automatic observe();
    bit ev;
    string tag;
    ev = s2 && (t2 > 0) && ((t2 % ratio) == 0);
    check(result_valid == ev, "R1 R6", "result_valid", result_valid, ev);
    if (result_valid && ev) begin
      outs++;
      if (outs >= kord) begin
        if (outs > kord) tag = "R9";
        else if (pat == 2) tag = "R4";
        else tag = "R3";
        check(longint'(result) == expect_val(pat, ratio, kord), tag, "result",
              longint'(result), expect_val(pat, ratio, kord));
      end
    end
    check(settled == (outs >= kord), "R5", "settled", settled, (outs >= kord));
  endtask

  task automatic tick(input bit en, input bit b);
    mod_en = en;
    bit_in = b;
    s2 = s1;
    t2 = t1;
    if (en) total++;
    s1 = en;
    t1 = total;
    @(negedge clk);
    observe();
  endtask

  task automatic do_restart(input int fs, input bit ord);
    restart   = 1'b1;
    mod_en    = 1'b1;  // R7: this sample must be discarded
    bit_in    = 1'b1;
    fs_word   = FS_W'(fs);
    order_sel = ord;
    s1 = 1'b0; s2 = 1'b0; t1 = 0; t2 = 0; total = 0; outs = 0;
    ratio = 16 * ((fs == 0) ? 1 : fs);
    kord  = ord ? 4 : 3;
    @(negedge clk);
    restart = 1'b0;
    check(!result_valid && !settled && (result == '0), "R7", "state after restart",
          longint'(result) + longint'(result_valid) + longint'(settled), 0);
    // R2: later changes to the configuration pins must not matter
    fs_word   = ~FS_W'(fs);
    order_sel = ~ord;
  endtask

  task automatic run(input int fs, input bit ord, input int p, input bit gap);
    int c = 0;
    pat = p;
    do_restart(fs, ord);
    while (outs < kord + 2) begin
      bit en;
      bit b;
      en = gap ? ((c % 3) != 2) : 1'b1;
      if (!en) b = (c % 2) == 0;  // R8: garbage while disabled
      else if (p == 0) b = 1'b1;
      else if (p == 1) b = 1'b0;
      else b = (total % 2) == 0;
      tick(en, b);
      c++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!result_valid && !settled && (result == '0), "R5", "reset state",
          longint'(result) + longint'(result_valid) + longint'(settled), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int fs = 0; fs < (1 << FS_W); fs++) begin
      for (int ord = 0; ord < 2; ord++) begin
        for (int p = 0; p < 3; p++) begin
          run(fs, ord[0], p, ((fs + p) % 2) == 1);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule